// File: doc/BRIEF.md
# Start/Stop to Synchronous Character Rate Adapter

This block takes a start/stop framed serial character stream and re-times it onto a bit stream paced by an external synchronous transmit clock. The asynchronous line is sampled with a 16x oversampling enable taken from the system clock. Each accepted character goes into a two-entry buffer. A serializer then sends it out one bit per rising edge of the synchronous clock. The sync clock is resynchronized inside the block and turned into a one-cycle strobe.

The two sides never run at exactly the same rate. When the character source is slow, the serializer sends mark between characters whenever the buffer is empty. When the source is fast, the serializer may leave out the stop bit of one character, but only if the next character is already waiting, and only within a rationed window of characters. Long spaces are regenerated: a space shorter than 2M+3 bit times comes out as exactly 2M+3 space bits, and a longer one comes out at about its own length. A bypass select routes the line straight through with no framing.

Top module: `a2s_adapter`

## Requirements
- R1: The format code `fmt` sets the character length M = 8 + fmt (00→8, 01→9, 10→10, 11→11). Each frame is one start bit of 0, then N = M − 2 data bits sent least significant bit first, then one stop bit of 1, on both the input and the output.
- R2: After reset, `sync_out` is 1. Outside bypass, `sync_out` changes only in the few system clock cycles that follow a rising edge of `sync_clk`.
- R3: When the buffer holds no character, the output sends mark (1). Every received character is sent out once, unchanged and in arrival order, whether the source is slower than or equal to the sync clock.
- R4: When the source is faster, a stop bit is dropped only while another character is already waiting. The next start bit then directly follows the last data bit. Between two dropped stop bits there are at least 7 characters with a full stop bit when `ext_range`=0, or at least 3 when `ext_range`=1.
- R5: A low pulse shorter than half a bit time on `async_in` is not taken as a start bit, and the output stays mark.
- R6: A continuous space on `async_in` lasting from M up to but not including 2M+3 bit times is sent as exactly 2M+3 consecutive output bits of 0.
- R7: A continuous space of 2M+3 bit times or more is sent as a run of 0 bits whose length matches the input duration to within two bit times.
- R8: With `bypass`=1, `sync_out` equals `async_in` delayed by one system clock, and the framing logic receives a constant mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Oversampling enable, 16 pulses per asynchronous bit time |
| async_in | input | 1 | Start/stop framed serial input, idle 1 |
| sync_clk | input | 1 | External synchronous transmit bit clock (raw, asynchronous) |
| fmt | input | 2 | Character length code, M = 8 + fmt |
| ext_range | input | 1 | 0: basic rate range, 1: extended rate range |
| bypass | input | 1 | 1: pass `async_in` straight to `sync_out` |
| sync_out | output | 1 | Synchronous data output |

## Verification
A wrong receiver bit index or sample point shows up as a corrupted data field in the first character sent out, about M bit times after the input. A buffer pointer or count fault shows up as a repeated, lost or reordered character within one or two characters. A rationing counter that is off shows up as two dropped stop bits closer together than the window allows, which becomes visible as soon as the second drop occurs during an over-speed run. A wrong break counter makes the regenerated space run too short or too long, which can be measured when the output returns to mark.

// File: rtl/a2s_pkg.sv
package a2s_pkg;

    localparam int MAX_DATA = 9;

    typedef struct packed {
        logic                brk;
        logic [MAX_DATA-1:0] data;
    } a2s_item_t;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_BREAK, RX_HUNT
    } rx_state_t;

    typedef enum logic [1:0] {
        SR_MARK, SR_FRAME, SR_BRK
    } sr_state_t;

    function automatic logic [3:0] data_bits(input logic [1:0] f);
        return 4'd6 + {2'b00, f};
    endfunction

    function automatic logic [3:0] char_len(input logic [1:0] f);
        return 4'd8 + {2'b00, f};
    endfunction

    function automatic logic [7:0] brk_len(input logic [1:0] f);
        return {3'b000, char_len(f), 1'b0} + 8'd3;
    endfunction

endpackage

// File: rtl/a2s_rx.sv
module a2s_rx
    import a2s_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       os_tick,
    input  logic       line_in,
    input  logic [1:0] fmt,
    output logic       push,
    output a2s_item_t  item,
    output logic       brk_active
);
    localparam int CW  = $clog2(OSR);
    localparam int MID = OSR / 2;

    rx_state_t           st;
    logic [CW-1:0]       cnt;
    logic [3:0]          idx;
    logic [MAX_DATA-1:0] data;
    logic                l1, l2;
    logic [2:0]          samp;
    logic                maj, eval, bit_end;
    logic [3:0]          nbits;

    assign nbits   = data_bits(fmt);
    assign maj     = (samp[0] & samp[1]) | (samp[1] & samp[2]) | (samp[0] & samp[2]);
    assign eval    = os_tick && (cnt == CW'(MID + 1));
    assign bit_end = os_tick && (cnt == CW'(OSR - 1));
    assign brk_active = (st == RX_BREAK);

    always_ff @(posedge clk) begin
        if (rst) begin
            l1 <= 1'b1; l2 <= 1'b1; samp <= 3'b111;
            st <= RX_IDLE; cnt <= '0; idx <= '0; data <= '0;
            push <= 1'b0; item <= '0;
        end else begin
            l1 <= line_in;
            l2 <= l1;
            push <= 1'b0;
            if (os_tick) samp <= {samp[1:0], l2};
            if (os_tick && st != RX_IDLE)
                cnt <= (cnt == CW'(OSR - 1)) ? '0 : cnt + 1'b1;
            unique case (st)
                RX_IDLE: if (os_tick && !l2) begin
                    st <= RX_START; cnt <= CW'(1); data <= '0;
                end
                RX_START: begin
                    if (eval && maj) st <= RX_IDLE;
                    else if (bit_end) begin st <= RX_DATA; idx <= '0; end
                end
                RX_DATA: begin
                    if (eval) data[idx] <= maj;
                    if (bit_end) begin
                        if (idx == nbits - 4'd1) st <= RX_STOP;
                        else idx <= idx + 4'd1;
                    end
                end
                RX_STOP: if (eval) begin
                    if (maj) begin
                        push <= 1'b1; item <= '{brk: 1'b0, data: data}; st <= RX_IDLE;
                    end else if (data == '0) begin
                        push <= 1'b1; item <= '{brk: 1'b1, data: '0}; st <= RX_BREAK;
                    end else st <= RX_HUNT;
                end
                default: if (l2) st <= RX_IDLE;
            endcase
        end
    end

    // R6: a break item is only produced when the line has gone to space
    a_r6_break_on_space: assert property (@(posedge clk) disable iff (rst)
        (push && item.brk) |-> !l2);

endmodule

// File: rtl/a2s_fifo.sv
module a2s_fifo
    import a2s_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      push,
    input  a2s_item_t din,
    input  logic      pop,
    output a2s_item_t head,
    output logic      empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    a2s_item_t     mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          full, do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp <= '0; rp <= '0; cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // R3: characters are only taken from a non-empty buffer
    a_r3_pop_nonempty: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);
    // R3: occupancy never exceeds the buffer depth
    a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));

endmodule

// File: rtl/a2s_ser.sv
module a2s_ser
    import a2s_pkg::*;
#(
    parameter int RATION_BASIC = 7,
    parameter int RATION_EXT   = 3,
    parameter int RW           = 4,
    parameter int BW           = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      bit_stb,
    input  logic [1:0] fmt,
    input  logic      ext_range,
    input  logic      brk_active,
    input  logic      empty,
    input  a2s_item_t head,
    output logic      pop,
    output logic      ser_bit
);
    sr_state_t           st;
    logic [3:0]          pos, tail;
    logic [MAX_DATA-1:0] shreg;
    logic [RW-1:0]       ration, thr;
    logic [BW-1:0]       bcnt;
    logic [3:0]          nbits, mlen;
    logic                del_ok;

    assign nbits  = data_bits(fmt);
    assign mlen   = char_len(fmt);
    assign thr    = ext_range ? RW'(RATION_EXT) : RW'(RATION_BASIC);
    assign del_ok = !empty && !head.brk && (ration >= thr);

    always_comb begin
        pop = 1'b0;
        if (bit_stb) begin
            if (st == SR_MARK)                         pop = !empty;
            else if (st == SR_FRAME && pos == nbits)   pop = del_ok;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= SR_MARK; pos <= '0; tail <= '0; shreg <= '0;
            ration <= '1; bcnt <= '0; ser_bit <= 1'b1;
        end else if (bit_stb) begin
            unique case (st)
                SR_MARK: begin
                    if (!empty && head.brk) begin
                        st <= SR_BRK; ser_bit <= 1'b0; bcnt <= BW'(1); tail <= '0;
                    end else if (!empty) begin
                        st <= SR_FRAME; ser_bit <= 1'b0; pos <= '0; shreg <= head.data;
                    end else ser_bit <= 1'b1;
                end
                SR_FRAME: begin
                    if (pos != nbits) begin
                        ser_bit <= shreg[pos]; pos <= pos + 4'd1;
                    end else if (pop) begin
                        ser_bit <= 1'b0; pos <= '0; shreg <= head.data; ration <= '0;
                    end else begin
                        ser_bit <= 1'b1; st <= SR_MARK;
                        if (ration != '1) ration <= ration + 1'b1;
                    end
                end
                default: begin
                    if (bcnt >= brk_len(fmt) && tail >= mlen) begin
                        ser_bit <= 1'b1; st <= SR_MARK;
                    end else begin
                        ser_bit <= 1'b0;
                        if (bcnt != '1) bcnt <= bcnt + 1'b1;
                        if (!brk_active && tail != 4'hF) tail <= tail + 4'd1;
                    end
                end
            endcase
        end
    end

    // R6: a regenerated space never ends before 2M+3 bits have gone out
    a_r6_break_min: assert property (@(posedge clk) disable iff (rst)
        ($past(st) == SR_BRK && st == SR_MARK) |-> bcnt >= brk_len(fmt));
    // R4: a dropped stop bit is always followed at once by a start bit
    a_r4_drop_starts: assert property (@(posedge clk) disable iff (rst)
        (st == SR_FRAME && pos == nbits && pop) |=> (!ser_bit && pos == 4'd0));

endmodule

// File: rtl/a2s_adapter.sv
module a2s_adapter
    import a2s_pkg::*;
#(
    parameter int OSR       = 16,
    parameter int BUF_DEPTH = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       os_tick,
    input  logic       async_in,
    input  logic       sync_clk,
    input  logic [1:0] fmt,
    input  logic       ext_range,
    input  logic       bypass,
    output logic       sync_out
);
    logic [2:0] sc;
    logic       bit_stb, byp_q, push, pop, empty, brk_active, ser_bit, rx_line;
    a2s_item_t  rx_item, head;

    assign bit_stb  = sc[1] & ~sc[2];
    assign rx_line  = bypass ? 1'b1 : async_in;
    assign sync_out = bypass ? byp_q : ser_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            sc <= '0; byp_q <= 1'b1;
        end else begin
            sc    <= {sc[1:0], sync_clk};
            byp_q <= async_in;
        end
    end

    a2s_rx #(.OSR(OSR)) u_rx (
        .clk(clk), .rst(rst), .os_tick(os_tick), .line_in(rx_line), .fmt(fmt),
        .push(push), .item(rx_item), .brk_active(brk_active));

    a2s_fifo #(.DEPTH(BUF_DEPTH)) u_buf (
        .clk(clk), .rst(rst), .push(push), .din(rx_item), .pop(pop),
        .head(head), .empty(empty));

    a2s_ser u_ser (
        .clk(clk), .rst(rst), .bit_stb(bit_stb), .fmt(fmt), .ext_range(ext_range),
        .brk_active(brk_active), .empty(empty), .head(head), .pop(pop),
        .ser_bit(ser_bit));

    // R2: outside bypass the output moves only on a sync clock strobe
    a_r2_out_on_strobe: assert property (@(posedge clk) disable iff (rst)
        (!bypass && !bit_stb) |=> (bypass || $stable(sync_out)));
    // R8: in bypass the output is the input one clock later
    a_r8_bypass_follow: assert property (@(posedge clk) disable iff (rst)
        bypass |=> (!bypass || sync_out == $past(async_in)));

endmodule

// File: tb/a2s_adapter_test.sv
`timescale 1ns/1ps
module a2s_adapter_test;
    localparam int  CLK_NS = 10;
    localparam int  BIT_NS = 16 * CLK_NS;

    typedef struct {
        bit         brk;
        logic [8:0] data;
        int         lo;
        int         hi;
    } exp_t;

    logic clk = 1'b0, rst = 1'b1, async_in = 1'b1, sync_clk = 1'b0;
    logic [1:0] fmt = 2'b00;
    logic ext_range = 1'b0, bypass = 1'b0;
    logic sync_out;
    real  sync_half = 80.0;
    int   checks = 0, fails = 0, drops = 0, ration = 15;
    bit   mon_on = 1'b1, done = 1'b0;
    exp_t q[$];

    a2s_adapter uut (
        .clk(clk), .rst(rst), .os_tick(1'b1), .async_in(async_in), .sync_clk(sync_clk),
        .fmt(fmt), .ext_range(ext_range), .bypass(bypass), .sync_out(sync_out));

    always #(CLK_NS / 2) clk = ~clk;

    initial begin
        #3;
        forever begin #(sync_half) sync_clk = ~sync_clk; end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int nbits();
        return 6 + int'(fmt);
    endfunction

    task automatic send_char(input logic [8:0] d);
        exp_t e;
        logic [8:0] m;
        m = d & ((9'h1 << nbits()) - 9'h1);
        e.brk = 1'b0; e.data = m; e.lo = 0; e.hi = 0;
        q.push_back(e);
        async_in = 1'b0; #(BIT_NS);
        for (int i = 0; i < nbits(); i++) begin async_in = m[i]; #(BIT_NS); end
        async_in = 1'b1; #(BIT_NS);
    endtask

    task automatic send_space(input int nb, input int lo, input int hi);
        exp_t e;
        e.brk = 1'b1; e.data = '0; e.lo = lo; e.hi = hi;
        q.push_back(e);
        async_in = 1'b0; #(nb * BIT_NS);
        async_in = 1'b1;
    endtask

    // scoreboard monitor: decodes the sync stream at falling sync edges
    initial begin
        bit pend = 1'b0;
        logic [8:0] d;
        logic stp;
        int zeros;
        exp_t e;
        forever begin
            if (!pend) begin
                @(negedge sync_clk);
                if (!mon_on || sync_out) continue;
            end
            pend = 1'b0;
            d = '0;
            for (int i = 0; i < nbits(); i++) begin @(negedge sync_clk); d[i] = sync_out; end
            @(negedge sync_clk); stp = sync_out;
            if (q.size() == 0) begin
                check(1'b0, "R3/R5 unexpected frame", int'(d), -1);
                continue;
            end
            e = q.pop_front();
            if (d == '0 && !stp) begin
                zeros = nbits() + 2;
                forever begin
                    @(negedge sync_clk);
                    if (sync_out) break;
                    zeros++;
                end
                check(e.brk && zeros >= e.lo && zeros <= e.hi, "R6/R7 space length",
                      zeros, e.lo);
            end else begin
                check(!e.brk && d == e.data, "R1/R3 character", int'(d), int'(e.data));
                if (!stp) begin
                    drops++;
                    check(ration >= (ext_range ? 3 : 7), "R4 drop spacing", ration,
                          ext_range ? 3 : 7);
                    ration = 0;
                    pend = 1'b1;
                end else if (ration < 15) ration++;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        repeat (2) @(posedge clk);
        #1 check(sync_out === 1'b1, "R2 reset mark", int'(sync_out), 1);

        // R1 R3: equal rates, 8-bit frame
        for (int i = 0; i < 6; i++) send_char(9'(8'h15 + 9 * i));
        #(BIT_NS * 30);
        check(q.size() == 0, "R3 all delivered fmt00", q.size(), 0);

        // R5: short glitch
        async_in = 1'b0; #(4 * CLK_NS); async_in = 1'b1;
        #(BIT_NS * 30);
        check(sync_out === 1'b1, "R5 glitch ignored", int'(sync_out), 1);
        check(q.size() == 0, "R5 no frame", q.size(), 0);

        // R3: slower source, 11-bit frame
        fmt = 2'b11; sync_half = 78.0;
        for (int i = 0; i < 8; i++) send_char(9'(9'h1A5 ^ (37 * i)));
        #(BIT_NS * 40);
        check(q.size() == 0, "R3 all delivered slow source", q.size(), 0);

        // R4: faster source, extended range, 10-bit frame
        fmt = 2'b10; ext_range = 1'b1; sync_half = 81.5; drops = 0;
        for (int i = 0; i < 16; i++) send_char(9'(8'h81 + 13 * i));
        #(BIT_NS * 40);
        check(q.size() == 0, "R4 all delivered ext", q.size(), 0);
        check(drops > 0, "R4 stop bits dropped ext", drops, 1);

        // R4: faster source, basic range, 9-bit frame
        fmt = 2'b01; ext_range = 1'b0; sync_half = 80.6;
        for (int i = 0; i < 16; i++) send_char(9'(7'h33 + 5 * i));
        #(BIT_NS * 40);
        check(q.size() == 0, "R4 all delivered basic", q.size(), 0);

        // R6: short space, M=10 -> 23 bits
        fmt = 2'b10; sync_half = 80.0;
        #(BIT_NS * 10);
        send_space(14, 23, 23);
        #(BIT_NS * 50);
        check(q.size() == 0, "R6 short space seen", q.size(), 0);

        // R7: long space of 40 bits
        send_space(40, 38, 42);
        #(BIT_NS * 50);
        check(q.size() == 0, "R7 long space seen", q.size(), 0);

        // R1: character after spaces still decodes
        send_char(9'h0B5);
        #(BIT_NS * 30);
        check(q.size() == 0, "R1 char after space", q.size(), 0);

        // R8: bypass
        mon_on = 1'b0;
        @(posedge clk); #1 bypass = 1'b1;
        for (int i = 0; i < 6; i++) begin
            async_in = i[0];
            repeat (3) @(posedge clk);
            #1 check(sync_out === async_in, "R8 bypass follow", int'(sync_out), int'(async_in));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule